// File: doc/BRIEF.md
# Descriptor DMA Command Sequencer

This block steps a single DMA channel through a chain of 16-byte command descriptors held in memory. While the channel's ACTIVE status bit is set, it reads the descriptor at the command pointer and decodes it. It then carries out the command: it can hand an output or input transfer to an external data mover, copy one word in either direction between memory and the descriptor, or stop the channel. After every command except stop, it writes the channel status and the residual byte count back into the descriptor.

Two fields in each descriptor control where the chain goes next. A wait code can hold the sequencer until a condition taken from the status word turns false, or until software raises WAKE. A branch code then either jumps to the address in the descriptor's third word or moves on to the next sequential descriptor. Both codes test the same condition bit. That bit compares the masked status word against a value, and both the mask and the value come from a 32-bit select input.

The memory port is a simple request/acknowledge port, 32 bits wide. The data mover is driven through a request/done handshake and returns the residual count.

Top module: `desc_cmd_seq`

## Requirements
- R1: After reset, cmd_ptr is 0 and mem_req, xfer_req, clr_active and clr_wake are all low.
- R2: A ptr_wr_en pulse while the sequencer is idle loads cmd_ptr with ptr_wr_data, with bits 3:0 forced to zero.
- R3: A fetch starts only while status bit 10 (ACTIVE) is set. The fetch reads words at cmd_ptr, +4, +8 and +12 in that order. clr_wake (which clears status bit 8, WAKE) pulses for exactly one cycle per fetch.
- R4: Descriptor word 0 holds the request count in bits 15:0, the opcode in bits 31:28, the branch code in 19:18 and the wait code in 17:16. Word 1 holds the data address. Opcodes 0 to 3 raise xfer_req with xfer_addr set to word 1, xfer_len set to the request count, xfer_in set to opcode bit 1 and xfer_last set to opcode bit 0. mem_req and xfer_req are never high together.
- R5: On completion, one write to cmd_ptr+12 stores {status_in, residual}: status in the upper half, residual in the lower half. For a transfer, the residual is the value of xfer_resid when xfer_done arrives.
- R6: When dev_present is low, a transfer opcode raises no xfer_req and completes with the residual equal to the request count.
- R7: Opcode 4 writes word 2 to the data address. Opcode 5 reads the data address and writes that word to cmd_ptr+8. Both complete with residual 0, and the branch target stays the word 2 that was fetched.
- R8: Opcode 7, and any undefined opcode (6 or 8 to 15), pulses clr_active for one cycle. It makes no write and leaves cmd_ptr unchanged.
- R9: The condition bit is true when (status_in & sel_word[31:16]) equals (sel_word[15:0] & sel_word[31:16]).
- R10: Wait codes: 0 never waits, 1 waits while the condition is true, 2 waits while it is false, 3 always waits. While waiting, cmd_ptr holds and no memory request is made. Setting WAKE, or a change of condition that ends the wait, releases it.
- R11: Branch codes use the same encoding as wait codes. A taken branch loads cmd_ptr with word 2 with bits 3:0 cleared. Otherwise cmd_ptr advances by 16.
- R12: mem_req stays asserted, with mem_addr and mem_we unchanged, until mem_ack. xfer_req stays asserted, with xfer_addr unchanged, until xfer_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr_en | input | 1 | Load the command pointer (idle only) |
| ptr_wr_data | input | 32 | New command pointer value |
| cmd_ptr | output | 32 | Current command pointer |
| status_in | input | 16 | Channel status word |
| sel_word | input | 32 | Condition mask (upper half) and value (lower half) |
| clr_active | output | 1 | One-cycle request to clear ACTIVE |
| clr_wake | output | 1 | One-cycle request to clear WAKE |
| dev_present | input | 1 | A data mover is attached |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory request completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_in | output | 1 | Transfer direction, 1 = input |
| xfer_last | output | 1 | Transfer ends a packet |
| xfer_addr | output | 32 | Transfer data address |
| xfer_len | output | 16 | Requested byte count |
| xfer_done | input | 1 | Transfer has finished |
| xfer_resid | input | 16 | Residual count, valid with xfer_done |

## Verification
The hardest situation to reach is the wait hold, which only arises after a full fetch, execute and writeback in which the masked status happens to satisfy the wait code. The stimulus builds the select word from the status it will present, so the condition comes out true or false on purpose. Once the bench sees the writeback, it confirms that the pointer is frozen. It then releases the hold, sometimes by raising WAKE and sometimes by rewriting the select word so the condition flips. The branch outcome is checked against the condition as it stands at the moment of release.

// File: rtl/desc_cmd_seq.sv
module desc_cmd_seq #(
  parameter int ACT_BIT  = 10,
  parameter int WAKE_BIT = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ptr_wr_en,
  input  logic [31:0] ptr_wr_data,
  output logic [31:0] cmd_ptr,
  input  logic [15:0] status_in,
  input  logic [31:0] sel_word,
  output logic        clr_active,
  output logic        clr_wake,
  input  logic        dev_present,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        xfer_req,
  output logic        xfer_in,
  output logic        xfer_last,
  output logic [31:0] xfer_addr,
  output logic [15:0] xfer_len,
  input  logic        xfer_done,
  input  logic [15:0] xfer_resid
);
  localparam logic [31:0] STRIDE   = 32'(DESC_BYTES);
  localparam logic [31:0] ALIGN    = ~(STRIDE - 32'd1);
  localparam logic [31:0] OFS_DEP  = STRIDE - 32'd8;
  localparam logic [31:0] OFS_STAT = STRIDE - 32'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_XFER, S_LDR, S_LDW, S_STW, S_WB, S_WAIT
  } st_t;

  st_t         state;
  logic [1:0]  beat;
  logic [31:0] ptr, daddr, dep, ld_data;
  logic [15:0] req_cnt, resid;
  logic [3:0]  op;
  logic [1:0]  brc, wtc;
  logic        wake_q;

  wire active = status_in[ACT_BIT];
  wire wake   = status_in[WAKE_BIT];
  wire cond   = ((status_in & sel_word[31:16]) == (sel_word[15:0] & sel_word[31:16]));
  wire hold   = !wake && (wtc == 2'd3 || (wtc == 2'd1 && cond) || (wtc == 2'd2 && !cond));
  wire take   = brc == 2'd3 || (brc == 2'd1 && cond) || (brc == 2'd2 && !cond);
  wire is_io  = op[3:2] == 2'b00;
  wire is_st  = op == 4'd4;
  wire is_ld  = op == 4'd5;

  assign cmd_ptr    = ptr;
  assign clr_wake   = wake_q;
  assign clr_active = state == S_EXEC && !is_io && !is_st && !is_ld;
  assign mem_req    = state inside {S_FETCH, S_LDR, S_LDW, S_STW, S_WB};
  assign mem_we     = state inside {S_LDW, S_STW, S_WB};
  assign xfer_req   = state == S_XFER;
  assign xfer_in    = op[1];
  assign xfer_last  = op[0];
  assign xfer_addr  = daddr;
  assign xfer_len   = req_cnt;

  always_comb begin
    mem_addr  = ptr;
    mem_wdata = 32'd0;
    case (state)
      S_FETCH:     mem_addr = ptr + {28'd0, beat, 2'b00};
      S_LDR:       mem_addr = daddr;
      S_STW: begin mem_addr = daddr;          mem_wdata = dep;                end
      S_LDW: begin mem_addr = ptr + OFS_DEP;  mem_wdata = ld_data;            end
      S_WB:  begin mem_addr = ptr + OFS_STAT; mem_wdata = {status_in, resid}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; beat <= '0; ptr <= '0; daddr <= '0; dep <= '0;
      ld_data <= '0; req_cnt <= '0; resid <= '0; op <= '0; brc <= '0;
      wtc <= '0; wake_q <= 1'b0;
    end else begin
      wake_q <= 1'b0;
      case (state)
        S_IDLE:
          if (ptr_wr_en) ptr <= ptr_wr_data & ALIGN;
          else if (active) begin
            beat <= '0; wake_q <= 1'b1; state <= S_FETCH;
          end
        S_FETCH:
          if (mem_ack) begin
            case (beat)
              2'd0: begin
                req_cnt <= mem_rdata[15:0]; op <= mem_rdata[31:28];
                brc <= mem_rdata[19:18];    wtc <= mem_rdata[17:16];
              end
              2'd1: daddr <= mem_rdata;
              2'd2: dep <= mem_rdata;
              default: ;
            endcase
            beat <= beat + 2'd1;
            if (beat == 2'd3) state <= S_EXEC;
          end
        S_EXEC:
          if (is_io) begin
            if (dev_present) state <= S_XFER;
            else begin resid <= req_cnt; state <= S_WB; end
          end else if (is_st) begin resid <= '0; state <= S_STW; end
          else if (is_ld) begin resid <= '0; state <= S_LDR; end
          else state <= S_IDLE;
        S_XFER:
          if (xfer_done) begin resid <= xfer_resid; state <= S_WB; end
        S_LDR:
          if (mem_ack) begin ld_data <= mem_rdata; state <= S_LDW; end
        S_LDW, S_STW:
          if (mem_ack) state <= S_WB;
        S_WB:
          if (mem_ack) state <= S_WAIT;
        S_WAIT:
          if (!hold) begin
            ptr   <= take ? (dep & ALIGN) : ptr + STRIDE;
            state <= S_IDLE;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_cmd_seq_chk.sv
module desc_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cmd_ptr,
  input logic        clr_active,
  input logic        dev_present,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        xfer_req,
  input logic [31:0] xfer_addr,
  input logic        xfer_done
);
  assert_stop_keeps_ptr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |=> $stable(cmd_ptr));
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> !mem_req && !xfer_req);
  assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  assert_xfer_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done |=> xfer_req && $stable(xfer_addr));
  assert_nodev_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> dev_present);
  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));
endmodule

bind desc_cmd_seq desc_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ptr(cmd_ptr), .clr_active(clr_active),
  .dev_present(dev_present), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .xfer_req(xfer_req),
  .xfer_addr(xfer_addr), .xfer_done(xfer_done)
);

// File: tb/tb_desc_cmd_seq.sv
module tb_desc_cmd_seq;
  localparam int ACT = 10, WK = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, ptr_wr_en = 1'b0, dev_present = 1'b1;
  logic [31:0] ptr_wr_data = '0, sel_word = '0, mem_rdata = '0;
  logic [15:0] status_in = '0, xfer_resid = '0;
  logic        mem_ack = 1'b0, xfer_done = 1'b0;
  logic [31:0] cmd_ptr, mem_addr, mem_wdata, xfer_addr;
  logic [15:0] xfer_len;
  logic        clr_active, clr_wake, mem_req, mem_we, xfer_req, xfer_in, xfer_last;

  desc_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .cmd_ptr(cmd_ptr), .status_in(status_in), .sel_word(sel_word),
    .clr_active(clr_active), .clr_wake(clr_wake), .dev_present(dev_present),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_in(xfer_in),
    .xfer_last(xfer_last), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_done(xfer_done), .xfer_resid(xfer_resid)
  );

  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:3];
  logic [31:0] cur_ptr, wb_data, x_addr;
  logic [15:0] x_len, x_res;
  logic        x_in, x_last;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int nrd, nwr, nx, n_ca, n_cw;
  bit wb_hit, pend_clr;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=%0d cycles expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
    mem_ack = 1'b0; xfer_done = 1'b0;
    if (pend_clr) begin status_in[ACT] = 1'b0; pend_clr = 1'b0; end
    if (mem_req && $urandom_range(0, 3) != 0) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata; nwr++;
        if (mem_addr == cur_ptr + 32'd12) begin wb_hit = 1'b1; wb_data = mem_wdata; end
      end else begin
        mem_rdata = mem[mem_addr[9:2]];
        if (nrd < 4) rd_log[nrd] = mem_addr;
        nrd++;
      end
    end
    if (xfer_req && $urandom_range(0, 2) != 0) begin
      xfer_done = 1'b1;
      xfer_resid = 16'($urandom_range(0, int'(xfer_len)));
      x_addr = xfer_addr; x_len = xfer_len; x_in = xfer_in; x_last = xfer_last;
      x_res = xfer_resid; nx++;
    end
    if (clr_active) begin n_ca++; status_in[ACT] = 1'b0; end
    if (clr_wake) begin n_cw++; status_in[WK] = 1'b0; pend_clr = 1'b1; end
  endtask

  task automatic load_ptr(input logic [31:0] v);
    ptr_wr_en = 1'b1; ptr_wr_data = v;
    tick();
    ptr_wr_en = 1'b0;
  endtask

  function automatic bit cond_f(input logic [15:0] st, input logic [31:0] sel);
    return (st & sel[31:16]) == (sel[15:0] & sel[31:16]);
  endfunction

  function automatic bit hold_f(input logic [1:0] w, input bit c, input bit wk);
    return !wk && (w == 2'd3 || (w == 2'd1 && c) || (w == 2'd2 && !c));
  endfunction

  function automatic logic [31:0] next_f(input logic [1:0] b, input bit c,
                                         input logic [31:0] p, input logic [31:0] d);
    bit tk = b == 2'd3 || (b == 2'd1 && c) || (b == 2'd2 && !c);
    return tk ? (d & 32'hFFFF_FFF0) : p + 32'd16;
  endfunction

  task automatic run_trial(input int t);
    logic [31:0] ptr0, daddr, dep, src, sel, exp_ptr;
    logic [15:0] base, req, exp_res;
    logic [3:0]  op;
    logic [1:0]  brc, wtc;
    bit dev, io, st, ld, c, c2;
    int k;
    ptr0  = 32'($urandom_range(0, 31)) * 32'd16;
    daddr = 32'h200 + 32'($urandom_range(0, 127)) * 32'd4;
    dep = $urandom; src = $urandom; req = 16'($urandom);
    if (t < 7) op = (t == 6) ? 4'd7 : 4'(t);
    else begin
      k = $urandom_range(0, 9);
      op = (k <= 5) ? 4'(k) : (k <= 7 ? 4'd7 : 4'($urandom_range(6, 15)));
    end
    brc = 2'($urandom); wtc = 2'($urandom);
    dev = (t < 4) ? 1'b1 : ($urandom_range(0, 3) != 0);
    base = 16'($urandom) & ~(16'(1) << ACT) & ~(16'(1) << WK);
    sel[31:16] = 16'($urandom) & 16'h00FF;
    sel[15:0]  = $urandom_range(0, 1) ? base : 16'($urandom);
    io = op[3:2] == 2'b00; st = op == 4'd4; ld = op == 4'd5;

    load_ptr(ptr0 | 32'($urandom_range(0, 15)));
    check(cmd_ptr == ptr0, "R2 pointer load aligned", cmd_ptr, ptr0);
    mem[ptr0[9:2]]     = {op, 8'($urandom), brc, wtc, req};
    mem[ptr0[9:2] + 1] = daddr;
    mem[ptr0[9:2] + 2] = dep;
    mem[ptr0[9:2] + 3] = 32'hDEAD_BEEF;
    mem[daddr[9:2]]    = src;
    nrd = 0; nwr = 0; nx = 0; n_ca = 0; n_cw = 0; wb_hit = 1'b0; cur_ptr = ptr0;
    sel_word = sel; dev_present = dev;
    status_in = base | (16'(1) << ACT) | (16'($urandom_range(0, 1)) << WK);
    for (int i = 0; i < 400 && !wb_hit && n_ca == 0; i++) tick();

    check(n_cw == 1, "R3 single clr_wake per fetch", 32'(n_cw), 32'd1);
    for (int j = 0; j < 4; j++)
      check(nrd > j && rd_log[j] == ptr0 + 32'(4 * j), "R3 fetch order", rd_log[j], ptr0 + 32'(4 * j));

    if (!io && !st && !ld) begin
      check(n_ca == 1, "R8 stop pulses clr_active", 32'(n_ca), 32'd1);
      repeat (3) tick();
      check(cmd_ptr == ptr0, "R8 stop keeps pointer", cmd_ptr, ptr0);
      check(nwr == 0 && nx == 0, "R8 stop makes no write", 32'(nwr + nx), 32'd0);
      return;
    end

    if (io && dev) begin
      check(nx == 1, "R4 one transfer", 32'(nx), 32'd1);
      check(x_addr == daddr && x_len == req, "R4 transfer addr/len", x_addr, daddr);
      check(x_in == op[1] && x_last == op[0], "R4 transfer dir/last",
            {30'd0, x_in, x_last}, {30'd0, op[1], op[0]});
      exp_res = x_res;
    end else if (io) begin
      check(nx == 0, "R6 no transfer without device", 32'(nx), 32'd0);
      exp_res = req;
    end else begin
      exp_res = 16'd0;
      if (ld) check(mem[ptr0[9:2] + 2] == src, "R7 load-word into descriptor", mem[ptr0[9:2] + 2], src);
      else    check(mem[daddr[9:2]] == dep, "R7 store-word to address", mem[daddr[9:2]], dep);
    end
    check(wb_hit && wb_data == {base, exp_res}, (io && !dev) ? "R6 writeback" : "R5 writeback",
          wb_data, {base, exp_res});

    c = cond_f(base, sel);
    if (!hold_f(wtc, c, 1'b0)) begin
      repeat (3) tick();
      exp_ptr = next_f(brc, c, ptr0, dep);
      check(cmd_ptr == exp_ptr, (brc == 2'd1 || brc == 2'd2) ? "R9 R11 cond branch" : "R11 branch",
            cmd_ptr, exp_ptr);
    end else begin
      repeat (6) tick();
      check(cmd_ptr == ptr0 && !mem_req, "R10 wait holds", cmd_ptr, ptr0);
      if (wtc != 2'd3 && $urandom_range(0, 1)) begin
        sel_word = (wtc == 2'd2) ? 32'd0 : {16'h0001, 15'd0, ~base[0]};
        c2 = cond_f(status_in, sel_word);
      end else begin
        status_in[WK] = 1'b1;
        c2 = cond_f(status_in, sel_word);
      end
      repeat (3) tick();
      exp_ptr = next_f(brc, c2, ptr0, dep);
      check(cmd_ptr == exp_ptr, "R10 R11 release then branch", cmd_ptr, exp_ptr);
    end
  endtask

  initial begin
    void'($urandom(32'd917));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    cur_ptr = '0; wb_data = '0; nrd = 0; nwr = 0; nx = 0; n_ca = 0; n_cw = 0;
    wb_hit = 1'b0; pend_clr = 1'b0;
    repeat (3) tick();
    check(cmd_ptr == 32'd0, "R1 reset pointer", cmd_ptr, 32'd0);
    check({mem_req, xfer_req, clr_active, clr_wake} == 4'd0, "R1 reset outputs",
          {28'd0, mem_req, xfer_req, clr_active, clr_wake}, 32'd0);
    rst_n = 1'b1;
    tick();
    load_ptr(32'h0000_0127);
    check(cmd_ptr == 32'h120, "R2 pointer low bits cleared", cmd_ptr, 32'h120);
    status_in = 16'h00FF;
    repeat (10) tick();
    check(nrd == 0 && n_cw == 0, "R3 no fetch while inactive", 32'(nrd + n_cw), 32'd0);
    status_in = '0;
    for (int t = 0; t < 90; t++) run_trial(t);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule